// File: doc/BRIEF.md
# Segment Line Latch and Drive-Level Selector

This block sits behind the data capture stage of a passive-matrix segment driver. It holds one display line and turns each held bit into a 2-bit code that tells the analog switch for that output channel which of three voltages to drive: high (V0), middle (VM) or low (V1). A new line is taken from the capture buffer on each falling edge of the line strobe `strobe_i`. The alternation input `alt_i`, which sets the polarity of the drive waveform, is sampled on the same edge. Because each code depends on both the held bit and the sampled alternation value, flipping the alternation value from one line to the next gives a drive waveform with no DC component.

The blanking input `show_i` works without waiting for the strobe. While it is low, every channel shows the middle level. A narrow-panel mode, sampled on the strobe edge, takes only the first `NARROW` captured bits. It places them, in capture order, on a centred band of channels. Every channel outside the band is held at the not-selected level for the sampled alternation value. `line_i` is a parallel buffer that is read only on the strobe edge. It is not a stream and has no back-pressure: the capture side must hold it stable over the clock cycle in which the edge is detected. All inputs are synchronous to `clk`.

Top module: `seg_line_driver`

## Requirements
- R1: After reset the held line and the sampled alternation value are zero. All channels read code 2'b01 (VM) while `show_i` is low, and code 2'b00 (V1) once `show_i` is raised before any strobe.
- R2: The held line, the sampled alternation value and the sampled mode change only when a falling edge of `strobe_i` is detected: a clock edge on which `strobe_i` is 0 after being 1 on the previous edge. A rising strobe edge has no effect on `lvl_o`, and neither do changes on `line_i`, `alt_i` or `narrow_i` between falling edges.
- R3: While `show_i` is low, every channel code is 2'b01 (VM), whatever the held data and alternation value.
- R4: While `show_i` is high, a channel's code is 2'b10 (V0) when its held bit differs from the sampled alternation value, and 2'b00 (V1) when they are equal. Code 2'b11 never appears.
- R5: The alternation value is sampled on the strobe falling edge. Changing `alt_i` afterwards leaves `lvl_o` unchanged until the next falling edge.
- R6: With `narrow_i` low at the strobe edge, captured bit i (index 0 first) drives channel i (bits 2i+1:2i of `lvl_o`).
- R7: With `narrow_i` high at the strobe edge, captured bit j, for j below `NARROW`, drives channel j+(CHANNELS-NARROW)/2. With the defaults, bits 0..239 go to channels 40..279.
- R8: With `narrow_i` high, channels outside the band show the not-selected level: V1 (2'b00) when the sampled alternation value is 0, and V0 (2'b10) when it is 1.
- R9: `narrow_i` is sampled on the strobe falling edge. Changing it between edges does not remap the held line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Line strobe; its falling edge loads a new line |
| alt_i | input | 1 | Alternation (polarity) input, sampled on the strobe falling edge |
| show_i | input | 1 | Display enable; low forces all channels to the middle level |
| narrow_i | input | 1 | Narrow-panel mode select, sampled on the strobe falling edge |
| line_i | input | CHANNELS | Captured line from the capture buffer, bit 0 first in capture order |
| lvl_o | output | 2*CHANNELS | Level code per channel, 2 bits each: 00 V1, 01 VM, 10 V0 |

## Verification
A wrong held bit or mapping offset shows as a single channel with the wrong polarity. That error appears one clock after the strobe falling edge is seen and stays until the next line is loaded. A wrong sampled alternation value inverts every unblanked channel at once, and so does a load that fires on the wrong edge. A blanking fault shows on the same cycle that `show_i` changes, because that path has no register. The bench therefore compares the whole output vector after every load, after every change of `show_i`, and after input changes that must be ignored.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  function automatic logic [1:0] pick_level(input logic show, input logic bit_v, input logic alt);
    if (!show)
      return LVL_MID;
    else if (bit_v != alt)
      return LVL_HIGH;
    else
      return LVL_LOW;
  endfunction
endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe_i;
  end

  assign fall_o = prev_q & ~strobe_i;

  // R2: one falling edge yields exactly one load cycle
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/seg_line_map.sv
module seg_line_map #(
  parameter int CHANNELS = 320,
  parameter int NARROW   = 240
) (
  input  logic [CHANNELS-1:0] line_i,
  input  logic                narrow_i,
  output logic [CHANNELS-1:0] mapped_o
);
  localparam int BAND_LO = (CHANNELS - NARROW) / 2;
  localparam int BAND_HI = BAND_LO + NARROW;

  logic [CHANNELS-1:0] narrow_bits;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_map
    if (g >= BAND_LO && g < BAND_HI) begin : g_band
      assign narrow_bits[g] = line_i[g-BAND_LO];
    end else begin : g_edge
      assign narrow_bits[g] = 1'b0;
    end
  end

  assign mapped_o = narrow_i ? narrow_bits : line_i;
endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
  parameter int CHANNELS = 320,
  parameter int NARROW   = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [CHANNELS-1:0] bits_i,
  input  logic                alt_i,
  input  logic                narrow_i,
  output logic [CHANNELS-1:0] bits_o,
  output logic                alt_o,
  output logic                narrow_o
);
  localparam int BAND_LO = (CHANNELS - NARROW) / 2;
  localparam int BAND_HI = BAND_LO + NARROW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_o   <= '0;
      alt_o    <= 1'b0;
      narrow_o <= 1'b0;
    end else if (load_i) begin
      bits_o   <= bits_i;
      alt_o    <= alt_i;
      narrow_o <= narrow_i;
    end
  end

  logic [CHANNELS-1:0] outer_mask;
  for (genvar g = 0; g < CHANNELS; g++) begin : g_mask
    assign outer_mask[g] = (g < BAND_LO) || (g >= BAND_HI);
  end

  // R2: held line moves only on a detected falling edge
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(bits_o) && $stable(alt_o) && $stable(narrow_o));
  // R5: alternation value taken at the load cycle
  a_r5_alt_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> alt_o == $past(alt_i));
  // R8: in narrow mode the outer channels hold a zero bit
  a_r8_outer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_o |-> ((bits_o & outer_mask) == '0));
endmodule

// File: rtl/seg_level_sel.sv
module seg_level_sel
  import seg_drv_pkg::*;
#(
  parameter int CHANNELS = 320
) (
  input  logic                  show_i,
  input  logic [CHANNELS-1:0]   bits_i,
  input  logic                  alt_i,
  output logic [2*CHANNELS-1:0] lvl_o
);
  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    assign lvl_o[2*g +: 2] = pick_level(show_i, bits_i[g], alt_i);
  end
endmodule

// File: rtl/seg_line_driver.sv
module seg_line_driver
  import seg_drv_pkg::*;
#(
  parameter int CHANNELS = 320,
  parameter int NARROW   = 240
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe_i,
  input  logic                  alt_i,
  input  logic                  show_i,
  input  logic                  narrow_i,
  input  logic [CHANNELS-1:0]   line_i,
  output logic [2*CHANNELS-1:0] lvl_o
);
  logic                load;
  logic [CHANNELS-1:0] mapped;
  logic [CHANNELS-1:0] held;
  logic                held_alt;
  logic                held_narrow;

  seg_fall_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .fall_o   (load)
  );

  seg_line_map #(.CHANNELS(CHANNELS), .NARROW(NARROW)) u_map (
    .line_i   (line_i),
    .narrow_i (narrow_i),
    .mapped_o (mapped)
  );

  seg_line_latch #(.CHANNELS(CHANNELS), .NARROW(NARROW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .bits_i   (mapped),
    .alt_i    (alt_i),
    .narrow_i (narrow_i),
    .bits_o   (held),
    .alt_o    (held_alt),
    .narrow_o (held_narrow)
  );

  seg_level_sel #(.CHANNELS(CHANNELS)) u_sel (
    .show_i (show_i),
    .bits_i (held),
    .alt_i  (held_alt),
    .lvl_o  (lvl_o)
  );

  // R3: blanking forces every channel to the middle level
  a_r3_blank_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !show_i |-> lvl_o == {CHANNELS{LVL_MID}});

  // R4: with display on only the two outer levels appear, never 2'b11
  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    a_r4_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
      show_i |-> (lvl_o[2*g +: 2] == LVL_LOW || lvl_o[2*g +: 2] == LVL_HIGH));
  end

  // R2: with display on and no load, outputs hold
  a_r2_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && show_i && $past(show_i)) |=> ($stable(lvl_o) || !show_i));
endmodule

// File: tb/seg_line_driver_test.sv
`timescale 1ns/1ps
module seg_line_driver_test;
  localparam int CH = 320;
  localparam int NR = 240;
  localparam int LO = (CH - NR) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, alt = 1'b0, show = 1'b0, narrow = 1'b0;
  logic [CH-1:0] line = '0;
  logic [2*CH-1:0] lvl;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  logic [CH-1:0] exp_bits = '0;
  logic exp_alt = 1'b0;

  always #10 clk = ~clk;

  seg_line_driver #(.CHANNELS(CH), .NARROW(NR)) uut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .alt_i(alt),
    .show_i(show), .narrow_i(narrow), .line_i(line), .lvl_o(lvl)
  );

  function automatic logic [1:0] code_of(input logic s, input logic b, input logic a);
    if (!s) return 2'b01;
    return (b != a) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [2*CH-1:0] expect_vec();
    logic [2*CH-1:0] v;
    for (int i = 0; i < CH; i++) v[2*i +: 2] = code_of(show, exp_bits[i], exp_alt);
    return v;
  endfunction

  task automatic check(input string req);
    logic [2*CH-1:0] e;
    e = expect_vec();
    total++;
    if (lvl !== e) begin
      bad++;
      for (int i = 0; i < CH; i++) begin
        if (lvl[2*i +: 2] !== e[2*i +: 2]) begin
          $display("FAIL %s ch %0d got %b exp %b", req, i, lvl[2*i +: 2], e[2*i +: 2]);
          break;
        end
      end
    end
  endtask

  task automatic model_load();
    for (int i = 0; i < CH; i++) begin
      if (narrow) exp_bits[i] = (i >= LO && i < LO + NR) ? line[i-LO] : 1'b0;
      else        exp_bits[i] = line[i];
    end
    exp_alt = alt;
  endtask

  task automatic strobe_rise();
    @(negedge clk) strobe = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe_fall();
    @(negedge clk) strobe = 1'b0;
    model_load();
    @(negedge clk);
  endtask

  task automatic pulse();
    strobe_rise();
    strobe_fall();
  endtask

  task automatic rand_line();
    for (int i = 0; i < CH; i++) line[i] = 1'($urandom_range(0, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset blank");
    show = 1'b1; #1;
    check("R1 reset show");

    // full mode, both polarities
    rand_line(); alt = 1'b0; narrow = 1'b0; pulse();
    check("R6 R4 full alt0");
    alt = 1'b1; pulse();
    check("R4 full alt1");

    // alternation change after edge ignored
    @(negedge clk) alt = 1'b0; @(negedge clk);
    check("R5 alt after edge");

    // data change and rising edge only
    @(negedge clk) line = ~line; narrow = 1'b1;
    strobe_rise();
    check("R2 rise ignored");
    check("R9 narrow not applied");
    narrow = 1'b0;
    strobe_fall();
    check("R2 fall loads");

    // blanking
    @(negedge clk) show = 1'b0; #1;
    check("R3 blank");
    @(negedge clk) show = 1'b1; #1;
    check("R3 unblank");

    // narrow mode, all-ones line
    line = '1; narrow = 1'b1; alt = 1'b0; pulse();
    check("R7 R8 narrow alt0");
    alt = 1'b1; pulse();
    check("R8 narrow alt1");
    rand_line(); alt = 1'b0; pulse();
    check("R7 narrow random");
    @(negedge clk) narrow = 1'b0; @(negedge clk);
    check("R9 mode change held");

    // random mix
    for (int k = 0; k < 30; k++) begin
      rand_line();
      alt = 1'($urandom_range(0, 1));
      narrow = 1'($urandom_range(0, 1));
      pulse();
      check("R4 R6 R7 random");
      if (k % 5 == 0) begin
        @(negedge clk) show = 1'b0; #1;
        check("R3 random blank");
        @(negedge clk) show = 1'b1; #1;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule